// File: doc/BRIEF.md
# State-Enable Access Check Unit

This block decides, for one hart, whether software at the current privilege level may touch two pieces of extension state. The first is the jump-vector-table CSR, which the two table-jump instructions (cm.jt and cm.jalt) also read implicitly. The second is the mode in which floating-point instructions operate on the integer registers. The block holds the machine-level, hypervisor-level and supervisor-level state-enable registers (mstateen0, hstateen0, sstateen0) and serves CSR reads and writes to them. Each CSR write takes effect on the next clock edge.

Each cycle the block takes four inputs: the privilege mode, the virtualization flag, a pre-decoded instruction class and an optional CSR access. It returns two verdicts in the same cycle, one for the instruction and one for the CSR access. A verdict is allow, an illegal-instruction trap or a virtual-instruction trap. The trap layer follows from which register's enable bit is clear. Bit 1 gates the floating-point-in-integer-registers mode. It exists only while the static floating-point flag from misa is 0. Bit 2 gates the jump-vector-table CSR and the two table-jump instructions. All other compressed code-size instructions pass without a check.

Top module: `stateen_gate`

## Requirements
- R1: With priv_mode 3 (machine), both verdicts are allow (0) whatever the virtualization flag, the class, the address and the register contents.
- R2: Verdict encoding: 0 allow, 1 illegal, 2 virtual. When not virtualized, a gated item returns illegal in supervisor mode (priv_mode 1) if its bit is clear in mstateen0. In user mode (priv_mode 0, and the reserved code 2 treated as user) it returns illegal if its bit is clear in mstateen0 or in sstateen0.
- R3: When virtualized (virt_on 1, priv_mode not 3), a gated item returns illegal if its bit is clear in mstateen0. If the bit is set there but clear in hstateen0, it returns virtual. In virtual user mode the item also returns virtual when the bit is set in both mstateen0 and hstateen0 but clear in sstateen0.
- R4: Instruction class 2 (table jump) and CSR address 0x017 (jump-vector table) are both gated by bit 2. Class 0 (plain) and class 3 (other code-size instructions) always return allow.
- R5: With misa_f 1, bit 1 of mstateen0 reads 0 and ignores writes, so it also reads 0 in hstateen0 and sstateen0. Class 1 (floating point) and CSR addresses 0x001 to 0x003 always return allow.
- R6: With misa_f 0, class 1 and CSR addresses 0x001 to 0x003 are gated by bit 1 under the rules of R2 and R3.
- R7: Only bits 1 and 2 are implemented; all other bits read 0. hstateen0 reads as its stored bits ANDed with the mstateen0 view. sstateen0 reads through the hstateen0 view when accessed virtualized, and through the mstateen0 view otherwise. A write to a bit that reads 0 leaves that stored bit unchanged.
- R8: Address 0x30C (mstateen0) is allowed only in machine mode and is illegal elsewhere. Address 0x60C (hstateen0) is allowed in machine mode and in non-virtual supervisor mode, virtual when virtualized, and illegal in non-virtual user mode. Address 0x10C (sstateen0) is allowed in machine mode and in any supervisor mode, illegal in non-virtual user mode, and virtual in virtual user mode. A trapped access returns read data 0 and writes nothing.
- R9: Reset clears all three registers. Verdicts and read data are combinational in the cycle of the request. An allowed write is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| misa_f | input | 1 | Static floating-point-register flag from misa |
| priv_mode | input | 2 | 0 user, 1 supervisor, 3 machine (2 treated as user) |
| virt_on | input | 1 | Virtualization flag |
| insn_class | input | 2 | 0 plain, 1 floating point, 2 table jump, 3 other code-size |
| insn_verdict | output | 2 | Verdict for the instruction class |
| csr_valid | input | 1 | CSR access present this cycle |
| csr_addr | input | 12 | CSR address |
| csr_we | input | 1 | CSR access writes |
| csr_wdata | input | XLEN | CSR write data |
| csr_verdict | output | 2 | Verdict for the CSR access |
| csr_rdata | output | XLEN | Read data for the state-enable registers, else 0 |

## Verification
The hardest result to reach is the virtual-instruction trap in virtual user mode that comes from sstateen0 alone. It needs a bit that is set in both mstateen0 and hstateen0 but clear in sstateen0. Because writes through a masked view are dropped, the registers can only reach such a state in a particular order. The bench therefore opens mstateen0 fully from machine mode, writes hstateen0 and sstateen0, and then writes the final mstateen0 value. It repeats this for every combination of bits 1 and 2 and both misa_f values, and follows each setup with a sweep over all privilege and virtualization pairs. Random accesses from every mode then exercise dropped and trapped writes.

// File: rtl/stateen_pkg.sv
package stateen_pkg;

    localparam int CTL_W   = 3;
    localparam int BIT_FPX = 1;
    localparam int BIT_JVT = 2;
    localparam int NITEM   = 2;

    localparam logic [11:0] ADDR_MST    = 12'h30C;
    localparam logic [11:0] ADDR_HST    = 12'h60C;
    localparam logic [11:0] ADDR_SST    = 12'h10C;
    localparam logic [11:0] ADDR_JVT    = 12'h017;
    localparam logic [11:0] ADDR_FFLAGS = 12'h001;
    localparam logic [11:0] ADDR_FRM    = 12'h002;
    localparam logic [11:0] ADDR_FCSR   = 12'h003;

    typedef enum logic [1:0] {
        VERD_ALLOW   = 2'd0,
        VERD_ILLEGAL = 2'd1,
        VERD_VIRTUAL = 2'd2
    } verdict_e;

    typedef enum logic [1:0] {
        ICLS_PLAIN  = 2'd0,
        ICLS_FP     = 2'd1,
        ICLS_TBLJMP = 2'd2,
        ICLS_CODESZ = 2'd3
    } insn_class_e;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_MST,
        TGT_HST,
        TGT_SST,
        TGT_JVT,
        TGT_FP
    } csr_target_e;

    typedef struct packed {
        logic [CTL_W-1:0] mst;
        logic [CTL_W-1:0] hst;
        logic [CTL_W-1:0] sst;
    } ctl_regs_t;

    function automatic int item_bit(input int idx);
        return (idx == 0) ? BIT_FPX : BIT_JVT;
    endfunction

endpackage

// File: rtl/stateen_regs.sv
module stateen_regs
    import stateen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       wr_sel,
    input  logic [CTL_W-1:0] wr_mask,
    input  logic [CTL_W-1:0] wr_data,
    output ctl_regs_t        regs_q
);

    ctl_regs_t regs_d;

    function automatic logic [CTL_W-1:0] merge(input logic [CTL_W-1:0] old_v,
                                               input logic [CTL_W-1:0] new_v,
                                               input logic [CTL_W-1:0] msk);
        return (old_v & ~msk) | (new_v & msk);
    endfunction

    always_comb begin
        regs_d = regs_q;
        if (wr_sel[0]) regs_d.mst = merge(regs_q.mst, wr_data, wr_mask);
        if (wr_sel[1]) regs_d.hst = merge(regs_q.hst, wr_data, wr_mask);
        if (wr_sel[2]) regs_d.sst = merge(regs_q.sst, wr_data, wr_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

endmodule

// File: rtl/stateen_layer_eval.sv
module stateen_layer_eval
    import stateen_pkg::*;
(
    input  logic     m_bit,
    input  logic     h_bit,
    input  logic     s_bit,
    input  logic     is_mach,
    input  logic     is_virt,
    input  logic     is_user,
    output verdict_e verdict
);

    always_comb begin
        verdict = VERD_ALLOW;
        if (!is_mach) begin
            if (!m_bit) begin
                verdict = VERD_ILLEGAL;
            end else if (is_virt) begin
                if (!h_bit || (is_user && !s_bit)) verdict = VERD_VIRTUAL;
            end else if (is_user && !s_bit) begin
                verdict = VERD_ILLEGAL;
            end
        end
    end

endmodule

// File: rtl/stateen_csr_port.sv
module stateen_csr_port
    import stateen_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic             csr_valid,
    input  logic             csr_we,
    input  logic [11:0]      csr_addr,
    input  logic [XLEN-1:0]  csr_wdata,
    input  logic             is_mach,
    input  logic             is_virt,
    input  logic             is_user,
    input  verdict_e         fp_gate,
    input  verdict_e         jvt_gate,
    input  logic [CTL_W-1:0] m_mask,
    input  logic [CTL_W-1:0] h_mask,
    input  logic [CTL_W-1:0] s_mask,
    input  logic [CTL_W-1:0] m_view,
    input  logic [CTL_W-1:0] h_view,
    input  logic [CTL_W-1:0] s_view,
    output verdict_e         csr_verdict,
    output logic [XLEN-1:0]  csr_rdata,
    output logic [2:0]       wr_sel,
    output logic [CTL_W-1:0] wr_mask,
    output logic [CTL_W-1:0] wr_data
);

    csr_target_e tgt;
    logic        unused_wdata;

    assign unused_wdata = ^csr_wdata[XLEN-1:CTL_W];
    assign wr_data      = csr_wdata[CTL_W-1:0];

    always_comb begin
        case (csr_addr)
            ADDR_MST:                        tgt = TGT_MST;
            ADDR_HST:                        tgt = TGT_HST;
            ADDR_SST:                        tgt = TGT_SST;
            ADDR_JVT:                        tgt = TGT_JVT;
            ADDR_FFLAGS, ADDR_FRM, ADDR_FCSR: tgt = TGT_FP;
            default:                         tgt = TGT_NONE;
        endcase
    end

    always_comb begin
        csr_verdict = VERD_ALLOW;
        case (tgt)
            TGT_MST: if (!is_mach) csr_verdict = VERD_ILLEGAL;
            TGT_HST: begin
                if (!is_mach) begin
                    if (is_virt)      csr_verdict = VERD_VIRTUAL;
                    else if (is_user) csr_verdict = VERD_ILLEGAL;
                end
            end
            TGT_SST: begin
                if (!is_mach && is_user)
                    csr_verdict = is_virt ? VERD_VIRTUAL : VERD_ILLEGAL;
            end
            TGT_JVT: csr_verdict = jvt_gate;
            TGT_FP:  csr_verdict = fp_gate;
            default: csr_verdict = VERD_ALLOW;
        endcase
    end

    always_comb begin
        csr_rdata = '0;
        wr_sel    = 3'b000;
        wr_mask   = '0;
        if (csr_valid && csr_verdict == VERD_ALLOW) begin
            case (tgt)
                TGT_MST: begin
                    csr_rdata[CTL_W-1:0] = m_view;
                    wr_sel  = {2'b00, csr_we};
                    wr_mask = m_mask;
                end
                TGT_HST: begin
                    csr_rdata[CTL_W-1:0] = h_view;
                    wr_sel  = {1'b0, csr_we, 1'b0};
                    wr_mask = h_mask;
                end
                TGT_SST: begin
                    csr_rdata[CTL_W-1:0] = s_view;
                    wr_sel  = {csr_we, 2'b00};
                    wr_mask = s_mask;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/stateen_gate.sv
module stateen_gate
    import stateen_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter bit HAS_TBLJMP = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            misa_f,
    input  logic [1:0]      priv_mode,
    input  logic            virt_on,
    input  logic [1:0]      insn_class,
    output logic [1:0]      insn_verdict,
    input  logic            csr_valid,
    input  logic [11:0]     csr_addr,
    input  logic            csr_we,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [1:0]      csr_verdict,
    output logic [XLEN-1:0] csr_rdata
);

    localparam logic [CTL_W-1:0] FPX_ONE  = CTL_W'(1) << BIT_FPX;
    localparam logic [CTL_W-1:0] JVT_ONE  = CTL_W'(1) << BIT_JVT;
    localparam logic [CTL_W-1:0] IMPL_MSK = FPX_ONE | (HAS_TBLJMP ? JVT_ONE : '0);

    ctl_regs_t        regs_q;
    logic             is_mach, is_virt, is_user;
    logic [CTL_W-1:0] avail, m_view, h_view, s_mask, s_view;
    logic [2:0]       wr_sel;
    logic [CTL_W-1:0] wr_mask, wr_data;
    verdict_e         item_v [NITEM];
    verdict_e         fp_gate, jvt_gate, insn_v, csr_v;

    assign is_mach = (priv_mode == 2'd3);
    assign is_virt = virt_on && !is_mach;
    assign is_user = !is_mach && (priv_mode != 2'd1);

    always_comb begin
        avail = IMPL_MSK;
        if (misa_f) avail[BIT_FPX] = 1'b0;
    end

    assign m_view = regs_q.mst & avail;
    assign h_view = regs_q.hst & m_view;
    assign s_mask = is_virt ? h_view : m_view;
    assign s_view = regs_q.sst & s_mask;

    stateen_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sel  (wr_sel),
        .wr_mask (wr_mask),
        .wr_data (wr_data),
        .regs_q  (regs_q)
    );

    for (genvar gi = 0; gi < NITEM; gi++) begin : g_item
        localparam int B = item_bit(gi);
        stateen_layer_eval u_eval (
            .m_bit   (m_view[B]),
            .h_bit   (h_view[B]),
            .s_bit   (s_view[B]),
            .is_mach (is_mach),
            .is_virt (is_virt),
            .is_user (is_user),
            .verdict (item_v[gi])
        );
    end

    assign fp_gate  = misa_f ? VERD_ALLOW : item_v[0];
    assign jvt_gate = item_v[1];

    always_comb begin
        case (insn_class)
            ICLS_FP:     insn_v = fp_gate;
            ICLS_TBLJMP: insn_v = jvt_gate;
            default:     insn_v = VERD_ALLOW;
        endcase
    end

    stateen_csr_port #(.XLEN(XLEN)) u_csr (
        .csr_valid   (csr_valid),
        .csr_we      (csr_we),
        .csr_addr    (csr_addr),
        .csr_wdata   (csr_wdata),
        .is_mach     (is_mach),
        .is_virt     (is_virt),
        .is_user     (is_user),
        .fp_gate     (fp_gate),
        .jvt_gate    (jvt_gate),
        .m_mask      (avail),
        .h_mask      (m_view),
        .s_mask      (s_mask),
        .m_view      (m_view),
        .h_view      (h_view),
        .s_view      (s_view),
        .csr_verdict (csr_v),
        .csr_rdata   (csr_rdata),
        .wr_sel      (wr_sel),
        .wr_mask     (wr_mask),
        .wr_data     (wr_data)
    );

    assign insn_verdict = insn_v;
    assign csr_verdict  = csr_v;

endmodule

// File: rtl/stateen_gate_chk.sv
module stateen_gate_chk
    import stateen_pkg::*;
#(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            misa_f,
    input logic [1:0]      priv_mode,
    input logic            virt_on,
    input logic [1:0]      insn_class,
    input logic [1:0]      insn_verdict,
    input logic            csr_valid,
    input logic [11:0]     csr_addr,
    input logic            csr_we,
    input logic [XLEN-1:0] csr_wdata,
    input logic [1:0]      csr_verdict,
    input logic [XLEN-1:0] csr_rdata
);

    assert_mach_open_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_mode == 2'd3) |-> (insn_verdict == 2'd0 && csr_verdict == 2'd0));

    assert_no_virt_trap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !virt_on |-> (insn_verdict != 2'd2 && csr_verdict != 2'd2));

    assert_codesz_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_class == 2'd3 || insn_class == 2'd0) |-> insn_verdict == 2'd0);

    assert_fp_native_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (misa_f && insn_class == 2'd1) |-> insn_verdict == 2'd0);

    assert_fpx_ro_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_valid && misa_f && (csr_addr == ADDR_MST || csr_addr == ADDR_HST ||
                                 csr_addr == ADDR_SST)) |-> !csr_rdata[BIT_FPX]);

    assert_mst_machine_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_valid && csr_addr == ADDR_MST && priv_mode != 2'd3) |->
            (csr_verdict == 2'd1 && csr_rdata == '0));

    assert_write_visible_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_valid && !csr_we && csr_addr == ADDR_MST && priv_mode == 2'd3 && !misa_f &&
         $past(rst_n) &&
         $past(csr_valid && csr_we && csr_addr == ADDR_MST && priv_mode == 2'd3 && !misa_f))
        |-> csr_rdata[BIT_FPX] == $past(csr_wdata[BIT_FPX]));

endmodule

bind stateen_gate stateen_gate_chk #(.XLEN(XLEN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .misa_f       (misa_f),
    .priv_mode    (priv_mode),
    .virt_on      (virt_on),
    .insn_class   (insn_class),
    .insn_verdict (insn_verdict),
    .csr_valid    (csr_valid),
    .csr_addr     (csr_addr),
    .csr_we       (csr_we),
    .csr_wdata    (csr_wdata),
    .csr_verdict  (csr_verdict),
    .csr_rdata    (csr_rdata)
);

// File: tb/sim_stateen_gate.sv
module sim_stateen_gate;

    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 64;
    localparam logic [11:0] A_MST = 12'h30C, A_HST = 12'h60C, A_SST = 12'h10C;
    localparam logic [11:0] A_JVT = 12'h017, A_FCSR = 12'h003;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            misa_f = 1'b0;
    logic [1:0]      priv_mode = 2'd3;
    logic            virt_on = 1'b0;
    logic [1:0]      insn_class = 2'd0;
    logic [1:0]      insn_verdict;
    logic            csr_valid = 1'b0;
    logic [11:0]     csr_addr = 12'h0;
    logic            csr_we = 1'b0;
    logic [XLEN-1:0] csr_wdata = '0;
    logic [1:0]      csr_verdict;
    logic [XLEN-1:0] csr_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    logic [2:0] mq = 3'b0, hq = 3'b0, sq = 3'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stateen_gate u0 (.*);

    function automatic logic [2:0] f_avail(input logic mf);
        return {1'b1, ~mf, 1'b0};
    endfunction

    function automatic logic [2:0] f_smask(input logic [1:0] pr, input logic vt, input logic mf);
        logic [2:0] mv;
        mv = mq & f_avail(mf);
        return (vt && pr != 2'd3) ? (hq & mv) : mv;
    endfunction

    function automatic logic [1:0] ref_item(input logic [1:0] pr, input logic vt,
                                            input logic mf, input int k);
        logic mach, virt, usr;
        logic [2:0] mv, hv, sv;
        mach = (pr == 2'd3);
        virt = vt && !mach;
        usr  = !mach && pr != 2'd1;
        mv = mq & f_avail(mf);
        hv = hq & mv;
        sv = sq & f_smask(pr, vt, mf);
        if (mach) return 2'd0;
        if (!mv[k]) return 2'd1;
        if (virt) begin
            if (!hv[k] || (usr && !sv[k])) return 2'd2;
            return 2'd0;
        end
        if (usr && !sv[k]) return 2'd1;
        return 2'd0;
    endfunction

    function automatic logic [1:0] ref_insn(input logic [1:0] pr, input logic vt,
                                            input logic mf, input logic [1:0] cls);
        if (cls == 2'd1) return mf ? 2'd0 : ref_item(pr, vt, mf, 1);
        if (cls == 2'd2) return ref_item(pr, vt, mf, 2);
        return 2'd0;
    endfunction

    function automatic logic [1:0] ref_csr(input logic [1:0] pr, input logic vt,
                                           input logic mf, input logic [11:0] ad);
        logic mach, virt, usr;
        mach = (pr == 2'd3);
        virt = vt && !mach;
        usr  = !mach && pr != 2'd1;
        case (ad)
            A_MST:  return mach ? 2'd0 : 2'd1;
            A_HST:  return mach ? 2'd0 : (virt ? 2'd2 : (usr ? 2'd1 : 2'd0));
            A_SST:  return (!mach && usr) ? (virt ? 2'd2 : 2'd1) : 2'd0;
            A_JVT:  return ref_item(pr, vt, mf, 2);
            12'h001, 12'h002, 12'h003: return mf ? 2'd0 : ref_item(pr, vt, mf, 1);
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic [2:0] ref_view(input logic [1:0] pr, input logic vt,
                                            input logic mf, input logic [11:0] ad);
        logic [2:0] mv;
        mv = mq & f_avail(mf);
        case (ad)
            A_MST: return mv;
            A_HST: return hq & mv;
            A_SST: return sq & f_smask(pr, vt, mf);
            default: return 3'b0;
        endcase
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [XLEN-1:0] got, input logic [XLEN-1:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic step(input logic [1:0] pr, input logic vt, input logic mf,
                        input logic [1:0] cls, input logic cv, input logic we,
                        input logic [11:0] ad, input logic [XLEN-1:0] wd, input string tag);
        logic [1:0] ec;
        logic [2:0] msk;
        @(negedge clk);
        priv_mode = pr; virt_on = vt; misa_f = mf; insn_class = cls;
        csr_valid = cv; csr_we = we; csr_addr = ad; csr_wdata = wd;
        #1;
        chk(tag, "insn_verdict", XLEN'(insn_verdict), XLEN'(ref_insn(pr, vt, mf, cls)));
        if (cv) begin
            ec = ref_csr(pr, vt, mf, ad);
            chk(tag, "csr_verdict", XLEN'(csr_verdict), XLEN'(ec));
            chk(tag, "csr_rdata", csr_rdata,
                (ec == 2'd0) ? XLEN'(ref_view(pr, vt, mf, ad)) : '0);
            if (we && ec == 2'd0) begin
                case (ad)
                    A_MST: begin msk = f_avail(mf); mq = (mq & ~msk) | (wd[2:0] & msk); end
                    A_HST: begin msk = mq & f_avail(mf); hq = (hq & ~msk) | (wd[2:0] & msk); end
                    A_SST: begin msk = f_smask(pr, vt, mf); sq = (sq & ~msk) | (wd[2:0] & msk); end
                    default: ;
                endcase
            end
        end
    endtask

    function automatic string sweep_tag(input logic [1:0] pr, input logic vt,
                                        input logic mf, input logic [1:0] cls);
        string t;
        t = (pr == 2'd3) ? "R1" : (vt ? "R3" : "R2");
        if (cls == 2'd1) t = {t, mf ? " R5" : " R6"};
        if (cls == 2'd2 || cls == 2'd0) t = {t, " R4"};
        if (cls == 2'd3) t = {t, " R4 R7 R8"};
        return t;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [11:0] alist [8];
        alist = '{A_MST, A_HST, A_SST, A_JVT, A_FCSR, 12'h001, 12'h002, 12'h123};
        void'($urandom(32'h5eed_0a17));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state, combinational verdicts
        step(2'd3, 0, 0, 2'd0, 1, 0, A_MST, '0, "R9 reset");
        step(2'd1, 0, 0, 2'd2, 1, 0, A_JVT, '0, "R9 reset");
        step(2'd0, 0, 0, 2'd1, 1, 0, A_FCSR, '0, "R9 reset");

        // R7: writes through a closed view are dropped
        step(2'd3, 0, 0, 2'd0, 1, 1, A_SST, 64'h6, "R7 closed");
        step(2'd3, 0, 0, 2'd0, 1, 1, A_MST, 64'hFFFF_FFFF_FFFF_FFFF, "R7 open");
        step(2'd3, 0, 0, 2'd0, 1, 0, A_SST, '0, "R7 dropped");
        step(2'd3, 0, 0, 2'd0, 1, 0, A_MST, '0, "R7 R9 readback");
        // R8: trapped write leaves state alone
        step(2'd3, 0, 0, 2'd0, 1, 1, A_MST, 64'h2, "R8 setup");
        step(2'd1, 0, 0, 2'd0, 1, 1, A_MST, 64'h6, "R8 s-write");
        step(2'd3, 0, 0, 2'd0, 1, 0, A_MST, '0, "R8 unchanged");
        // R5: bit 1 read-only zero under misa_f
        step(2'd3, 0, 1, 2'd0, 1, 1, A_MST, 64'h6, "R5 write");
        step(2'd3, 0, 1, 2'd0, 1, 0, A_MST, '0, "R5 read");
        step(2'd3, 0, 0, 2'd0, 1, 0, A_MST, '0, "R5 stored");

        // Exhaustive sweep over bit settings, misa_f, modes
        for (int mf = 0; mf < 2; mf++)
            for (int mv = 0; mv < 4; mv++)
                for (int hv = 0; hv < 4; hv++)
                    for (int sv = 0; sv < 4; sv++) begin
                        step(2'd3, 0, mf[0], 2'd0, 1, 1, A_MST, 64'h6, "R7 prog");
                        step(2'd3, 0, mf[0], 2'd0, 1, 1, A_HST, XLEN'(hv << 1), "R7 prog");
                        step(2'd3, 0, mf[0], 2'd0, 1, 1, A_SST, XLEN'(sv << 1), "R7 prog");
                        step(2'd3, 0, mf[0], 2'd0, 1, 1, A_MST, XLEN'(mv << 1), "R7 prog");
                        for (int pr = 0; pr < 4; pr++)
                            for (int vt = 0; vt < 2; vt++)
                                for (int cls = 0; cls < 4; cls++) begin
                                    logic [11:0] ad;
                                    case (cls)
                                        0: ad = A_JVT;
                                        1: ad = A_FCSR;
                                        2: ad = A_SST;
                                        default: ad = A_HST;
                                    endcase
                                    step(pr[1:0], vt[0], mf[0], cls[1:0], 1, 0, ad, '0,
                                         sweep_tag(pr[1:0], vt[0], mf[0], cls[1:0]));
                                end
                    end

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] rp;
            rp = 2'($urandom_range(0, 3));
            step(rp, 1'($urandom), 1'($urandom_range(0, 3) == 0), 2'($urandom),
                 1'($urandom_range(0, 3) != 0), 1'($urandom), alist[$urandom_range(0, 7)],
                 {$urandom, $urandom}, "R2 R3 R7 R8 rand");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule